// File: doc/BRIEF.md
# Startup Banner and Echo Arbiter

This block sits between a byte-wide serial receiver and a byte-wide serial transmitter. After every reset it pushes a fixed 16-character ASCII greeting into the transmitter, one byte per write pulse, and it paces itself on the transmitter's ready flag. Once the last greeting byte has gone out, it switches permanently into echo mode. From then on every byte reported by the receiver is handed back to the transmitter.

A single character counter does two jobs. It indexes the constant greeting, and its terminal value marks the end of the greeting phase. The transmit data lines are driven by one combinational selector, which picks the greeting character while the greeting runs and the echo byte afterwards. A one-entry holding slot absorbs a received byte that arrives while the transmitter is busy. A sticky flag records when such a held byte was lost to a newer one.

The transmitter is expected to drop its ready flag in the cycle after it accepts a write, and to raise it again once it can take the next byte.

Top module: `greet_echo_top`

## Requirements
- R1: While reset (synchronous, active high) is asserted, and in the cycle after it, tx_write, banner_done and overrun are all low.
- R2: After reset, the first 16 write pulses carry the bytes of the string "Link up, ready." followed by a line feed (0x0A), in string order, and tx_byte equals the character during its pulse.
- R3: tx_write is high for exactly one cycle per byte. It only rises at a clock edge where tx_ready was high and tx_write was low.
- R4: banner_done goes high in the cycle right after the 16th greeting pulse and stays high until the next reset.
- R5: Receive strobes seen while banner_done is low are ignored: they cause no write and no overrun, and their bytes never appear on tx_byte during a pulse.
- R6: In echo mode each received byte is written to the transmitter exactly once, in arrival order, with tx_byte equal to that byte during its pulse.
- R7: A byte received while the transmitter is busy is held and is sent once tx_ready returns, with no overrun.
- R8: A byte received while the holding slot is full and not being sent replaces the held byte. The replaced byte is never sent, the newer one is, and overrun goes high and stays high until reset.
- R9: A reset during echo mode clears overrun and banner_done, and the full greeting is sent again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tx_ready | input | 1 | Transmitter can accept a byte |
| rx_strobe | input | 1 | One-cycle pulse: rx_byte holds a new received byte |
| rx_byte | input | 8 | Received byte |
| tx_write | output | 1 | One-cycle write pulse to the transmitter |
| tx_byte | output | 8 | Byte offered to the transmitter |
| banner_done | output | 1 | Greeting fully sent; echo mode active |
| overrun | output | 1 | Sticky: a held echo byte was overwritten |

## Verification
The bench injects receive strobes in the middle of the greeting. A design that listened too early would slip those bytes into the greeting or raise overrun. It also puts a byte into the cycle in which a previous echo byte is being written, and feeds two more bytes back to back while the transmitter is busy. A slot that overwrote the outgoing byte, lost the held byte, or failed to flag the replacement would show the wrong byte sequence or a low overrun. The bench checks that banner_done rises exactly one cycle after the 16th pulse: the classic mistake of decoding the done state too early drops or corrupts the last character. A final mid-echo reset shows whether the sticky flag and the counter truly restart.

// File: rtl/greet_echo_pkg.sv
package greet_echo_pkg;

    localparam int BYTE_W          = 8;
    localparam int BANNER_LEN_DEF  = 16;
    localparam logic [BANNER_LEN_DEF*BYTE_W-1:0] BANNER_TEXT_DEF = "Link up, ready.\n";

    typedef logic [BYTE_W-1:0] byte_t;

    // One-entry holding slot for an echo byte waiting on the transmitter
    typedef struct packed {
        logic  valid;
        byte_t data;
    } slot_t;

    function automatic bit is_pow2(input int n);
        return (n > 0) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/banner_seq.sv
module banner_seq
    import greet_echo_pkg::*;
#(
    parameter int LEN   = BANNER_LEN_DEF,
    parameter int CNT_W = $clog2(LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (advance && !done) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Terminal count: a single bit when the length is a power of two
    generate
        if (is_pow2(LEN)) begin : g_msb
            assign done = cnt[CNT_W-1];
        end else begin : g_cmp
            assign done = (cnt == CNT_W'(LEN));
        end
    endgenerate

endmodule

// File: rtl/banner_rom.sv
module banner_rom
    import greet_echo_pkg::*;
#(
    parameter int                       LEN   = BANNER_LEN_DEF,
    parameter int                       IDX_W = (LEN > 1) ? $clog2(LEN) : 1,
    parameter logic [LEN*BYTE_W-1:0]    TEXT  = BANNER_TEXT_DEF
) (
    input  logic [IDX_W-1:0] idx,
    output byte_t            ch
);

    // First character sits in the most significant byte of TEXT
    always_comb begin
        ch = '0;
        for (int k = 0; k < LEN; k++) begin
            if (idx == IDX_W'(k)) begin
                ch = TEXT[BYTE_W*(LEN-1-k) +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/echo_hold.sv
module echo_hold
    import greet_echo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  logic  rx_strobe,
    input  byte_t rx_byte,
    input  logic  take,
    output logic  pending,
    output byte_t out_byte,
    output logic  overrun
);

    slot_t slot_q;
    logic  capture;

    assign capture = enable && rx_strobe;
    assign pending = slot_q.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= '0;
            out_byte <= '0;
            overrun  <= 1'b0;
        end else begin
            // The byte being sent moves out before the slot can refill
            if (take) begin
                out_byte <= slot_q.data;
            end
            if (capture) begin
                slot_q.data  <= rx_byte;
                slot_q.valid <= 1'b1;
                if (slot_q.valid && !take) begin
                    overrun <= 1'b1;
                end
            end else if (take) begin
                slot_q.valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tx_src_mux.sv
module tx_src_mux
    import greet_echo_pkg::*;
(
    input  logic  echo_sel,
    input  byte_t banner_ch,
    input  byte_t echo_ch,
    output byte_t tx_byte
);

    assign tx_byte = echo_sel ? echo_ch : banner_ch;

endmodule

// File: rtl/greet_echo_top.sv
module greet_echo_top
    import greet_echo_pkg::*;
#(
    parameter int                    LEN  = BANNER_LEN_DEF,
    parameter logic [LEN*BYTE_W-1:0] TEXT = BANNER_TEXT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_ready,
    input  logic              rx_strobe,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              tx_write,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              banner_done,
    output logic              overrun
);

    localparam int CNT_W = $clog2(LEN + 1);
    localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1;

    logic             wr_q;
    logic             launch;
    logic [CNT_W-1:0] cnt;
    logic             done;
    logic             pend;
    byte_t            echo_ch;
    byte_t            banner_ch;

    // A new pulse needs a ready transmitter, no pulse in flight, and data
    assign launch = tx_ready && !wr_q && (done ? pend : 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b0;
        end else begin
            wr_q <= launch;
        end
    end

    // Counter steps after the pulse, so it indexes the byte on the lines
    banner_seq #(.LEN(LEN), .CNT_W(CNT_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .advance (wr_q),
        .cnt     (cnt),
        .done    (done)
    );

    banner_rom #(.LEN(LEN), .IDX_W(IDX_W), .TEXT(TEXT)) u_rom (
        .idx (cnt[IDX_W-1:0]),
        .ch  (banner_ch)
    );

    echo_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .enable    (done),
        .rx_strobe (rx_strobe),
        .rx_byte   (rx_byte),
        .take      (launch && done),
        .pending   (pend),
        .out_byte  (echo_ch),
        .overrun   (overrun)
    );

    tx_src_mux u_mux (
        .echo_sel  (done),
        .banner_ch (banner_ch),
        .echo_ch   (echo_ch),
        .tx_byte   (tx_byte)
    );

    assign tx_write    = wr_q;
    assign banner_done = done;

endmodule

// File: rtl/greet_echo_checker.sv
module greet_echo_checker (
    input logic clk,
    input logic rst,
    input logic tx_ready,
    input logic tx_write,
    input logic banner_done,
    input logic overrun
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!tx_write && !banner_done && !overrun)); // R1

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_write |=> !tx_write); // R3

    AST_READY_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_write) |-> $past(tx_ready)); // R3

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        banner_done |=> banner_done); // R4

    AST_NO_EARLY_OVR: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(banner_done)); // R5

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R8

endmodule

bind greet_echo_top greet_echo_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_ready    (tx_ready),
    .tx_write    (tx_write),
    .banner_done (banner_done),
    .overrun     (overrun)
);

// File: tb/greet_echo_top_test.sv
module greet_echo_top_test;

    localparam int CLK_P   = 10;
    localparam int GAP     = 6;
    localparam int WDOG    = 50000;
    localparam logic [127:0] EXP_TEXT = "Link up, ready.\n";

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_ready;
    logic       rx_strobe = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       tx_write;
    logic [7:0] tx_byte;
    logic       banner_done;
    logic       overrun;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int busy;
    int log_n;
    int hs_err;
    logic [7:0] wlog [64];
    logic prev_wr;
    logic prev_rdy;

    greet_echo_top uut (
        .clk         (clk),
        .rst         (rst),
        .tx_ready    (tx_ready),
        .rx_strobe   (rx_strobe),
        .rx_byte     (rx_byte),
        .tx_write    (tx_write),
        .tx_byte     (tx_byte),
        .banner_done (banner_done),
        .overrun     (overrun)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] exp_char(input int k);
        return EXP_TEXT[8*(15-k) +: 8];
    endfunction

    // Transmitter model: busy for GAP cycles after each accepted write
    always @(posedge clk) begin
        if (rst) begin
            tx_ready <= 1'b1;
            busy     <= 0;
        end else if (tx_write) begin
            tx_ready <= 1'b0;
            busy     <= GAP;
        end else if (busy != 0) begin
            busy <= busy - 1;
            if (busy == 1) tx_ready <= 1'b1;
        end
    end

    // Write monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst) begin
            log_n    = 0;
            hs_err   = 0;
            prev_wr  = 1'b0;
            prev_rdy = 1'b1;
        end else begin
            if (tx_write) begin
                if (log_n < 64) wlog[log_n] = tx_byte;
                log_n++;
                if (!prev_wr && !prev_rdy) hs_err++;
            end
            if (tx_write && prev_wr) hs_err++;
            prev_wr  = tx_write;
            prev_rdy = tx_ready;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<=%0d", cyc, WDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rx_strobe = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        rx_byte   = b;
        rx_strobe = 1'b1;
        tick();
        rx_strobe = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 1000 && !banner_done; i++) tick();
    endtask

    task automatic wait_write();
        for (int i = 0; i < 50 && !tx_write; i++) tick();
    endtask

    task automatic check_banner(input string req);
        check(log_n >= 16, req, "greeting byte count", log_n, 16);
        for (int k = 0; k < 16; k++) begin
            check(wlog[k] == exp_char(k), req, $sformatf("greeting byte %0d", k),
                  wlog[k], exp_char(k));
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        check(!tx_write && !banner_done && !overrun, "R1", "outputs in reset",
              {tx_write, banner_done, overrun}, 0);
        rst = 1'b0;
        tick();
        check(!banner_done && !overrun, "R1", "outputs after reset",
              {banner_done, overrun}, 0);
    endtask

    task automatic t_banner();
        logic seen_wr = 1'b0;
        int   pulses_before = 0;
        do_reset();
        for (int i = 0; i < 1000 && !banner_done; i++) begin
            seen_wr = tx_write;
            tick();
        end
        pulses_before = log_n;
        check(banner_done && seen_wr, "R4", "done one cycle after last pulse",
              {banner_done, seen_wr}, 3);
        check(pulses_before == 16, "R2", "pulses at done", pulses_before, 16);
        check_banner("R2");
        check(hs_err == 0, "R3", "handshake violations", hs_err, 0);
        repeat (30) tick();
        check(banner_done, "R4", "done holds", banner_done, 1);
        check(log_n == 16, "R2", "no extra writes", log_n, 16);
    endtask

    task automatic t_early_rx();
        do_reset();
        for (int i = 0; i < 5; i++) begin
            repeat (7) tick();
            send(8'hA5);
        end
        wait_done();
        repeat (30) tick();
        check(log_n == 16, "R5", "writes with early strobes", log_n, 16);
        check_banner("R5");
        check(!overrun, "R5", "no overrun from early strobes", overrun, 0);
    endtask

    task automatic t_echo();
        logic [7:0] bytes [3] = '{8'h31, 8'h7E, 8'h00};
        do_reset();
        wait_done();
        repeat (5) tick();
        for (int i = 0; i < 3; i++) begin
            send(bytes[i]);
            repeat (12) tick();
        end
        check(log_n == 19, "R6", "echo write count", log_n, 19);
        for (int i = 0; i < 3; i++) begin
            check(wlog[16+i] == bytes[i], "R6", $sformatf("echo byte %0d", i),
                  wlog[16+i], bytes[i]);
        end
        check(!overrun, "R6", "no overrun when spaced", overrun, 0);
    endtask

    task automatic t_hold();
        int base;
        base = log_n;
        send(8'h42);
        wait_write();
        send(8'h43);
        repeat (25) tick();
        check(log_n == base + 2, "R7", "held byte write count", log_n, base + 2);
        check(wlog[base] == 8'h42, "R7", "first byte", wlog[base], 8'h42);
        check(wlog[base+1] == 8'h43, "R7", "held byte", wlog[base+1], 8'h43);
        check(!overrun, "R7", "hold is not overrun", overrun, 0);
        check(hs_err == 0, "R7", "sent only while ready", hs_err, 0);
    endtask

    task automatic t_overrun();
        int base;
        base = log_n;
        send(8'h51);
        wait_write();
        send(8'h52);
        send(8'h53);
        check(overrun, "R8", "overrun raised", overrun, 1);
        repeat (25) tick();
        check(log_n == base + 2, "R8", "write count", log_n, base + 2);
        check(wlog[base] == 8'h51, "R8", "first byte", wlog[base], 8'h51);
        check(wlog[base+1] == 8'h53, "R8", "newest byte sent", wlog[base+1], 8'h53);
        check(overrun, "R8", "overrun sticky", overrun, 1);
    endtask

    task automatic t_rerun();
        rst = 1'b1;
        tick();
        tick();
        check(!overrun && !banner_done, "R9", "reset clears flags",
              {overrun, banner_done}, 0);
        rst = 1'b0;
        wait_done();
        repeat (5) tick();
        check(log_n == 16, "R9", "greeting resent count", log_n, 16);
        check_banner("R9");
    endtask

    initial begin
        t_reset();
        t_banner();
        t_early_rx();
        t_echo();
        t_hold();
        t_overrun();
        t_rerun();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule